// File: doc/BRIEF.md
# Memory Manager Register File

This block is an I/O-mapped control window for an 8-bit PC-style expansion bus. It holds four 16-bit expanded-memory page pointers and two base segments, one for an expanded-memory window and one for an upper-memory area. It also owns a region table that classifies every 2 KB slice of the 1 MB memory space. Memory decode logic elsewhere presents a 20-bit address on the lookup port and gets back the slice's 3-bit region tag in the same cycle.

Software sets up a memory area in two steps. It first writes a base segment, then writes a page count to one of two commit offsets. The block checks that the requested run lies wholly between segments 0xA000 and 0xF000. If it does, a sequencer retags one table entry per clock and holds a busy flag. A request that fails the check changes nothing. While the sequencer runs, every bus write is dropped.

Top module: `mm_region_ctrl`

## Requirements
- R1: The window decodes when (io_addr_i AND 0x0FF0) equals 0x0260, so 0x1265 decodes and 0x0270 and 0x025F do not. A write outside the window changes no register.
- R2: Offsets 0..7 hold page pointers 0..3, with the low byte at offset 2k and the high byte at 2k+1. A byte write changes only its own byte, and every pointer resets to 0xFFFF.
- R3: Tags are encoded Unused=0, Ram=1, EmsWindow=2, BootRom=3, SdCard=4. The lookup tag is the table entry at lookup_addr_i >> 11. At reset, entries for 0x00000–0x9FFFF are Ram and entries for 0xA0000–0xFFFFF are Unused.
- R4: Offsets 10/11 hold the expanded-window base segment (low/high byte). Writing N to offset 12 tags N*8 consecutive entries as EmsWindow, starting at entry base>>7.
- R5: Offsets 13/14 hold the upper-memory base segment (low/high byte). Writing N to offset 15 tags N consecutive entries as Ram, starting at entry base>>7.
- R6: A commit is carried out only if base ≥ 0xA000 and the end segment (base + N<<10 for offset 12, base + N<<7 for offset 15) is ≤ 0xF000. An end of exactly 0xF000 is accepted. Otherwise the table is unchanged and busy stays low.
- R7: With io_rd_i high and the window decoded, offsets 0..7 read back the pointer bytes and offset 15 reads the tag at entry (upper-memory base >> 7), zero-extended. Every other offset, a non-decoded address, or io_rd_i low reads 0xFF.
- R8: An accepted commit writes one entry per clock with consecutive indices. busy_o is high for exactly as many cycles as entries retagged. A count of zero never raises busy_o.
- R9: While busy_o is high, every I/O write is ignored, including pointer, segment and commit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | I/O write strobe, sampled each clock edge |
| io_rd_i | input | 1 | I/O read strobe, gates read data |
| io_wdata_i | input | 8 | I/O write data |
| io_hit_o | output | 1 | Address falls in the register window |
| io_rdata_o | output | 8 | Read data, combinational |
| lookup_addr_i | input | 20 | Memory address to classify |
| lookup_tag_o | output | 3 | Region tag of that address |
| busy_o | output | 1 | Commit sequence in progress |

## Verification
The bench probes the edges of the range check. It uses a base just below 0xA000, a run ending exactly at 0xF000, and runs that overshoot by one unit. A design with an off-by-one or a too-narrow sum would either refuse the legal run or spill tags into the reserved top 64 KB. It counts busy cycles for 1-, 3-, 8- and 32-entry commits and a zero-count commit, which exposes sequencers that stop one entry early or late. It probes the entries just outside each retagged run, where such errors show first. It also issues pointer and commit writes during a running commit; a design that let them through would show a changed pointer or a stray Ram tag afterwards. Byte-lane tests catch writes that clobber the neighbouring byte.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    TAG_UNUSED  = 3'd0,
    TAG_RAM     = 3'd1,
    TAG_EMS     = 3'd2,
    TAG_BOOTROM = 3'd3,
    TAG_SDCARD  = 3'd4
  } region_tag_e;

  localparam logic [3:0] OFF_EMS_SEG_LO = 4'd10;
  localparam logic [3:0] OFF_EMS_SEG_HI = 4'd11;
  localparam logic [3:0] OFF_EMS_COMMIT = 4'd12;
  localparam logic [3:0] OFF_UMB_SEG_LO = 4'd13;
  localparam logic [3:0] OFF_UMB_SEG_HI = 4'd14;
  localparam logic [3:0] OFF_UMB_COMMIT = 4'd15;
endpackage

// File: rtl/mm_regs.sv
module mm_regs
  import mm_pkg::*;
#(
  parameter logic [15:0] IO_BASE        = 16'h0260,
  parameter logic [15:0] SEG_LO         = 16'hA000,
  parameter logic [15:0] SEG_HI         = 16'hF000,
  parameter int          PAGE_SHIFT     = 11,
  parameter int          EMS_PAGE_SHIFT = 14,
  parameter int          IDX_W          = 9,
  parameter int          CNT_W          = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  input  region_tag_e       umb_tag_i,
  output logic              hit_o,
  output logic [7:0]        rdata_o,
  output logic [IDX_W-1:0]  umb_idx_o,
  output logic              cmt_start_o,
  output logic [IDX_W-1:0]  cmt_idx_o,
  output logic [CNT_W-1:0]  cmt_cnt_o,
  output region_tag_e       cmt_tag_o
);
  localparam int IDX_SHIFT = PAGE_SHIFT - 4;
  localparam int EMS_SHIFT = EMS_PAGE_SHIFT - 4;
  localparam int PER_PAGE  = EMS_PAGE_SHIFT - PAGE_SHIFT;
  localparam int SUM_W     = 17 + 8 + EMS_SHIFT;

  logic [15:0] ptr_q [4];
  logic [15:0] ems_seg_q, umb_seg_q;
  logic [3:0]  off;
  logic        wr_en;
  logic [SUM_W-1:0] ems_end, umb_end;
  logic        ems_ok, umb_ok;

  assign hit_o = (addr_i & 16'h0FF0) == IO_BASE;
  assign off   = addr_i[3:0];
  assign wr_en = wr_i && hit_o && !busy_i;

  for (genvar g = 0; g < 4; g++) begin : g_ptr
    localparam logic [3:0] OFF_LO = 4'(2 * g);
    localparam logic [3:0] OFF_HI = 4'(2 * g + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[g] <= 16'hFFFF;
      end else if (wr_en) begin
        if (off == OFF_LO) ptr_q[g][7:0]  <= wdata_i;
        if (off == OFF_HI) ptr_q[g][15:8] <= wdata_i;
      end
    end

    a_r2_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && off == OFF_LO) |=> $stable(ptr_q[g][15:8]));
    a_r2_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && off == OFF_HI) |=> $stable(ptr_q[g][7:0]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ems_seg_q <= '0;
      umb_seg_q <= '0;
    end else if (wr_en) begin
      unique case (off)
        OFF_EMS_SEG_LO: ems_seg_q[7:0]  <= wdata_i;
        OFF_EMS_SEG_HI: ems_seg_q[15:8] <= wdata_i;
        OFF_UMB_SEG_LO: umb_seg_q[7:0]  <= wdata_i;
        OFF_UMB_SEG_HI: umb_seg_q[15:8] <= wdata_i;
        default: ;
      endcase
    end
  end

  // range check on the segment scale, wide enough that no sum wraps
  assign ems_end = SUM_W'(ems_seg_q) + (SUM_W'(wdata_i) << EMS_SHIFT);
  assign umb_end = SUM_W'(umb_seg_q) + (SUM_W'(wdata_i) << IDX_SHIFT);
  assign ems_ok  = (ems_seg_q >= SEG_LO) && (ems_end <= SUM_W'(SEG_HI));
  assign umb_ok  = (umb_seg_q >= SEG_LO) && (umb_end <= SUM_W'(SEG_HI));

  assign umb_idx_o = IDX_W'(umb_seg_q >> IDX_SHIFT);

  always_comb begin
    cmt_start_o = 1'b0;
    cmt_idx_o   = IDX_W'(ems_seg_q >> IDX_SHIFT);
    cmt_cnt_o   = CNT_W'(wdata_i) << PER_PAGE;
    cmt_tag_o   = TAG_EMS;
    if (wr_en && wdata_i != 8'd0) begin
      if (off == OFF_EMS_COMMIT) begin
        cmt_start_o = ems_ok;
      end else if (off == OFF_UMB_COMMIT) begin
        cmt_start_o = umb_ok;
        cmt_idx_o   = umb_idx_o;
        cmt_cnt_o   = CNT_W'(wdata_i);
        cmt_tag_o   = TAG_RAM;
      end
    end
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (rd_i && hit_o) begin
      if (!off[3])                   rdata_o = off[0] ? ptr_q[off[2:1]][15:8] : ptr_q[off[2:1]][7:0];
      else if (off == OFF_UMB_COMMIT) rdata_o = {5'd0, umb_tag_i};
    end
  end

  a_r9_busy_freezes_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable({ptr_q[0], ptr_q[1], ptr_q[2], ptr_q[3], ems_seg_q, umb_seg_q}));
  a_r9_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !cmt_start_o);
endmodule

// File: rtl/mm_commit_seq.sv
module mm_commit_seq
  import mm_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  region_tag_e      tag_i,
  output logic             busy_o,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o,
  output region_tag_e      wtag_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] left_q;
  region_tag_e      tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      tag_q  <= TAG_UNUSED;
    end else if (busy_q) begin
      idx_q  <= idx_q + IDX_W'(1);
      left_q <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= cnt_i != '0;
      idx_q  <= start_idx_i;
      left_q <= cnt_i;
      tag_q  <= tag_i;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign widx_o = idx_q;
  assign wtag_o = tag_q;

  a_r8_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (idx_q - $past(idx_q)) == IDX_W'(1));
  a_r8_zero_never_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i && cnt_i == '0) |=> !busy_q);
endmodule

// File: rtl/mm_region_table.sv
module mm_region_table
  import mm_pkg::*;
#(
  parameter int IDX_W   = 9,
  parameter int ENTRIES = 512,
  parameter int RAM_IDX = 320,
  parameter int LO_IDX  = 320,
  parameter int HI_IDX  = 480
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  region_tag_e      wtag_i,
  input  logic [IDX_W-1:0] look_idx_i,
  output region_tag_e      look_tag_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output region_tag_e      rd_tag_o
);
  region_tag_e tag_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam region_tag_e RST_TAG = (e < RAM_IDX) ? TAG_RAM : TAG_UNUSED;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              tag_q[e] <= RST_TAG;
      else if (we_i && widx_i == IDX_W'(e))     tag_q[e] <= wtag_i;
    end
  end

  assign look_tag_o = tag_q[look_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];

  a_r6_write_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (widx_i >= IDX_W'(LO_IDX)) && (widx_i < IDX_W'(HI_IDX)));
  a_r4_tag_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wtag_i == TAG_EMS || wtag_i == TAG_RAM));
endmodule

// File: rtl/mm_region_ctrl.sv
module mm_region_ctrl
  import mm_pkg::*;
#(
  parameter logic [15:0] IO_BASE        = 16'h0260,
  parameter int          ADDR_W         = 20,
  parameter int          PAGE_SHIFT     = 11,
  parameter int          EMS_PAGE_SHIFT = 14,
  parameter logic [15:0] SEG_LO         = 16'hA000,
  parameter logic [15:0] SEG_HI         = 16'hF000,
  parameter logic [15:0] RAM_TOP_SEG    = 16'hA000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic              io_hit_o,
  output logic [7:0]        io_rdata_o,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic [2:0]        lookup_tag_o,
  output logic              busy_o
);
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT;
  localparam int ENTRIES   = 1 << IDX_W;
  localparam int CNT_W     = 8 + EMS_PAGE_SHIFT - PAGE_SHIFT;
  localparam int IDX_SHIFT = PAGE_SHIFT - 4;
  localparam int LO_IDX    = int'(SEG_LO) >> IDX_SHIFT;
  localparam int HI_IDX    = int'(SEG_HI) >> IDX_SHIFT;
  localparam int RAM_IDX   = int'(RAM_TOP_SEG) >> IDX_SHIFT;

  logic             busy;
  logic             cmt_start, we;
  logic [IDX_W-1:0] cmt_idx, umb_idx, widx;
  logic [CNT_W-1:0] cmt_cnt;
  region_tag_e      cmt_tag, wtag, umb_tag, look_tag;
  logic             unused_low;

  assign unused_low = ^lookup_addr_i[PAGE_SHIFT-1:0];

  mm_regs #(
    .IO_BASE(IO_BASE), .SEG_LO(SEG_LO), .SEG_HI(SEG_HI), .PAGE_SHIFT(PAGE_SHIFT),
    .EMS_PAGE_SHIFT(EMS_PAGE_SHIFT), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .addr_i(io_addr_i), .wr_i(io_wr_i), .rd_i(io_rd_i), .wdata_i(io_wdata_i),
    .busy_i(busy), .umb_tag_i(umb_tag),
    .hit_o(io_hit_o), .rdata_o(io_rdata_o), .umb_idx_o(umb_idx),
    .cmt_start_o(cmt_start), .cmt_idx_o(cmt_idx), .cmt_cnt_o(cmt_cnt), .cmt_tag_o(cmt_tag)
  );

  mm_commit_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(cmt_start), .start_idx_i(cmt_idx), .cnt_i(cmt_cnt), .tag_i(cmt_tag),
    .busy_o(busy), .we_o(we), .widx_o(widx), .wtag_o(wtag)
  );

  mm_region_table #(
    .IDX_W(IDX_W), .ENTRIES(ENTRIES), .RAM_IDX(RAM_IDX), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
  ) u_table (
    .clk_i, .rst_ni,
    .we_i(we), .widx_i(widx), .wtag_i(wtag),
    .look_idx_i(lookup_addr_i[ADDR_W-1:PAGE_SHIFT]), .look_tag_o(look_tag),
    .rd_idx_i(umb_idx), .rd_tag_o(umb_tag)
  );

  assign lookup_tag_o = look_tag;
  assign busy_o       = busy;
endmodule

// File: tb/mm_region_ctrl_tb.sv
module mm_region_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b1;
  logic [7:0]  io_wdata = '0;
  logic        io_hit;
  logic [7:0]  io_rdata;
  logic [19:0] look_addr = '0;
  logic [2:0]  look_tag;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int        kind;   // 0 rdata, 1 tag, 2 hit, 3 busy
    logic [7:0] exp;
    string     req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  mm_region_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd), .io_wdata_i(io_wdata),
    .io_hit_o(io_hit), .io_rdata_o(io_rdata),
    .lookup_addr_i(look_addr), .lookup_tag_o(look_tag), .busy_o(busy)
  );

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = io_rdata;
        1: act = {5'd0, look_tag};
        2: act = {7'd0, io_hit};
        default: act = {7'd0, busy};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [15:0] a, input logic [7:0] e, input string req);
    #1; io_addr = a;
    sb_q.push_back('{0, e, req});
    @(negedge clk);
  endtask

  task automatic exp_tag(input logic [19:0] a, input logic [2:0] e, input string req);
    #1; look_addr = a;
    sb_q.push_back('{1, {5'd0, e}, req});
    @(negedge clk);
  endtask

  task automatic exp_hit(input logic [15:0] a, input logic e, input string req);
    #1; io_addr = a;
    sb_q.push_back('{2, {7'd0, e}, req});
    @(negedge clk);
  endtask

  task automatic exp_busy(input logic e, input string req);
    #1;
    sb_q.push_back('{3, {7'd0, e}, req});
    @(negedge clk);
  endtask

  task automatic check_val(input int act, input int e, input string req);
    checks++;
    if (act != e) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, e);
    end
  endtask

  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 decode
    exp_hit(16'h0260, 1'b1, "R1");
    exp_hit(16'h1265, 1'b1, "R1");
    exp_hit(16'h0270, 1'b0, "R1");
    exp_hit(16'h025F, 1'b0, "R1");
    // R2 reset pointers
    for (int i = 0; i < 8; i++) exp_rd(16'h0260 + 16'(i), 8'hFF, "R2");
    // R3 reset table
    exp_tag(20'h00000, 3'd1, "R3");
    exp_tag(20'h9F800, 3'd1, "R3");
    exp_tag(20'hA0000, 3'd0, "R3");
    exp_tag(20'hFFFFF, 3'd0, "R3");

    // R2 byte lanes
    io_write(16'h0260, 8'h34);
    exp_rd(16'h0260, 8'h34, "R2");
    exp_rd(16'h0261, 8'hFF, "R2");
    io_write(16'h0261, 8'h12);
    exp_rd(16'h0260, 8'h34, "R2");
    exp_rd(16'h0261, 8'h12, "R2");
    io_write(16'h0267, 8'hAB);
    exp_rd(16'h0266, 8'hFF, "R2");
    exp_rd(16'h0267, 8'hAB, "R2");
    // R1 write outside window
    io_write(16'h0270, 8'h00);
    exp_rd(16'h0260, 8'h34, "R1");

    // R7 other offsets and gating
    for (int i = 8; i < 15; i++) exp_rd(16'h0260 + 16'(i), 8'hFF, "R7");
    exp_rd(16'h0270, 8'hFF, "R7");
    #1 io_rd = 1'b0;
    exp_rd(16'h0260, 8'hFF, "R7");
    #1 io_rd = 1'b1;

    // R4 EMS commit of 4 pages at 0xD000
    io_write(16'h026A, 8'h00);
    io_write(16'h026B, 8'hD0);
    exp_rd(16'h026A, 8'hFF, "R7");
    io_write(16'h026C, 8'd4);
    busy_len(n);
    check_val(n, 32, "R8 ems busy length");
    exp_tag(20'hCF800, 3'd0, "R4");
    exp_tag(20'hD0000, 3'd2, "R4");
    exp_tag(20'hDF800, 3'd2, "R4");
    exp_tag(20'hE0000, 3'd0, "R4");

    // R5 UMB commit of 3 slices at 0xE000
    io_write(16'h026D, 8'h00);
    io_write(16'h026E, 8'hE0);
    exp_rd(16'h026F, 8'h00, "R7");
    io_write(16'h026F, 8'd3);
    busy_len(n);
    check_val(n, 3, "R8 umb busy length");
    exp_tag(20'hE0000, 3'd1, "R5");
    exp_tag(20'hE17FF, 3'd1, "R5");
    exp_tag(20'hE1800, 3'd0, "R5");
    exp_rd(16'h026F, 8'h01, "R7");

    // R6 EMS base below window
    io_write(16'h026A, 8'h00);
    io_write(16'h026B, 8'h90);
    io_write(16'h026C, 8'd1);
    exp_busy(1'b0, "R6");
    exp_tag(20'h90000, 3'd1, "R6");
    // R6 EMS run past top
    io_write(16'h026B, 8'hE0);
    io_write(16'h026C, 8'd5);
    exp_busy(1'b0, "R6");
    exp_tag(20'hE2000, 3'd0, "R6");
    exp_tag(20'hE0000, 3'd1, "R6");
    // R6 EMS run ending exactly at top
    io_write(16'h026B, 8'hEC);
    io_write(16'h026C, 8'd1);
    busy_len(n);
    check_val(n, 8, "R8 ems boundary busy length");
    exp_tag(20'hEC000, 3'd2, "R6");
    exp_tag(20'hEFFFF, 3'd2, "R6");
    exp_tag(20'hEB800, 3'd0, "R6");
    exp_tag(20'hF0000, 3'd0, "R6");
    // R6 UMB boundary and overshoot
    io_write(16'h026D, 8'h80);
    io_write(16'h026E, 8'hEF);
    io_write(16'h026F, 8'd1);
    busy_len(n);
    check_val(n, 1, "R8 umb boundary busy length");
    exp_tag(20'hEF800, 3'd1, "R6");
    exp_tag(20'hEF7FF, 3'd2, "R6");
    io_write(16'h026F, 8'd2);
    exp_busy(1'b0, "R6");
    exp_tag(20'hF0000, 3'd0, "R6");
    // R8 zero count
    io_write(16'h026F, 8'd0);
    exp_busy(1'b0, "R8");
    exp_tag(20'hEF800, 3'd1, "R8");

    // R9 writes during a commit
    io_write(16'h026D, 8'h00);
    io_write(16'h026E, 8'hB0);
    io_write(16'h026A, 8'h00);
    io_write(16'h026B, 8'hA0);
    io_write(16'h026C, 8'd2);
    io_write(16'h0260, 8'h77);
    io_write(16'h026F, 8'd1);
    io_write(16'h026E, 8'hC0);
    busy_len(n);
    exp_rd(16'h0260, 8'h34, "R9");
    exp_tag(20'hB0000, 3'd0, "R9");
    exp_rd(16'h026F, 8'h00, "R9");
    exp_tag(20'hA0000, 3'd2, "R4");
    exp_tag(20'hA7800, 3'd2, "R4");
    exp_tag(20'hA8000, 3'd0, "R4");

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule